// File: doc/BRIEF.md
# Dual Wiper Register Bank

This block holds the register state of a pair of potentiometer channels. Each channel owns one 8-bit wiper code register, which sets the tap position, and a small bank of four 8-bit stored-setting registers, built here from ordinary flops. A command receiver upstream decodes the serial protocol and hands the block one decoded command per clock as a strobe with an opcode, a channel index, a bank index, a data byte and a step direction.

The block executes the command in the same clock edge. It supports the following commands:
- direct writes and reads of either register kind;
- copies between a stored setting and the wiper register of one channel, in either direction;
- gang copies that move every channel at once using a shared bank index;
- single-segment steps of one wiper, which stop at the ends of the range.

Read results appear on a registered read port. Both wiper codes are driven out continuously.

Top module: `wiper_bank`

## Requirements
- R1: After reset every wiper register, every stored-setting register and the read port hold 0x00.
- R2: Opcode 1 (write wiper) with a valid strobe loads `cmd_data` into the wiper of channel `cmd_pot`. The new code is visible on `wiper_codes` after that clock edge. Channel i occupies bits [8i+7:8i].
- R3: Opcode 2 (write setting) loads `cmd_data` into setting `cmd_reg` of channel `cmd_pot`. Opcode 4 (read setting) then returns that value on `rd_data` after the next edge.
- R4: Opcode 3 (read wiper) places the addressed channel's wiper code on `rd_data` after the edge and leaves all registers unchanged.
- R5: Opcode 5 copies setting `cmd_reg` of channel `cmd_pot` into that channel's wiper. The other channel is unchanged.
- R6: Opcode 6 copies the wiper of channel `cmd_pot` into its setting `cmd_reg`. No wiper changes.
- R7: Opcode 7 (gang load) sets every channel's wiper to that channel's setting `cmd_reg` in one edge, whatever the value of `cmd_pot`.
- R8: Opcode 8 (gang store) writes every channel's wiper into that channel's setting `cmd_reg` in one edge, whatever the value of `cmd_pot`.
- R9: Opcode 9 (step) moves the addressed wiper by exactly one code per command: up when `cmd_up` is 1 and down when it is 0.
- R10: A step up at 0xFF and a step down at 0x00 leave the wiper unchanged. It never wraps.
- R11: A `cmd_pot` value of 2 or 3 names no channel. Any non-gang command using it changes no register and leaves `rd_data` as it was.
- R12: With `cmd_valid` low, or with opcode 0, no register and no output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one command per clock |
| cmd_op | input | 4 | Opcode (0 idle, 1..9 as in the requirements) |
| cmd_pot | input | 2 | Channel index |
| cmd_reg | input | 2 | Stored-setting index |
| cmd_data | input | 8 | Data byte for the write opcodes |
| cmd_up | input | 1 | Step direction, 1 = up |
| wiper_codes | output | 16 | Wiper codes of both channels, channel 0 in the low byte |
| rd_data | output | 8 | Result of the last valid read |

## Verification
Every command takes effect at the first rising edge that sees the strobe. Both the wiper codes and the read port are therefore due one edge after the command is presented, and nothing takes longer. The bench drives each command on a falling edge and advances its behavioural model at the rising edge. It compares both outputs on the following falling edge, halfway through the cycle in which the result is first valid. Idle cycles go through the same compare, so any change that was not requested is caught in the cycle it appears.

// File: rtl/wbank_pkg.sv
package wbank_pkg;

    typedef enum logic [3:0] {
        OP_IDLE      = 4'd0,
        OP_WR_WIPER  = 4'd1,
        OP_WR_SET    = 4'd2,
        OP_RD_WIPER  = 4'd3,
        OP_RD_SET    = 4'd4,
        OP_LOAD      = 4'd5,
        OP_STORE     = 4'd6,
        OP_GANG_LOAD = 4'd7,
        OP_GANG_STOR = 4'd8,
        OP_STEP      = 4'd9
    } op_e;

endpackage

// File: rtl/wbank_decode.sv
module wbank_decode
    import wbank_pkg::*;
#(
    parameter int NCH   = 2,
    parameter int POT_W = 2
) (
    input  logic             valid_i,
    input  logic [3:0]       op_i,
    input  logic [POT_W-1:0] pot_i,
    output logic [NCH-1:0]   hit_o,
    output logic             gang_o,
    output logic             rd_en_o
);
    op_e  op;
    logic pot_ok;
    logic is_gang;

    always_comb begin
        op      = op_e'(op_i);
        pot_ok  = (int'(pot_i) < NCH);
        is_gang = (op == OP_GANG_LOAD) || (op == OP_GANG_STOR);
        gang_o  = valid_i && is_gang;
        rd_en_o = valid_i && pot_ok && ((op == OP_RD_WIPER) || (op == OP_RD_SET));
    end

    for (genvar i = 0; i < NCH; i++) begin : g_hit
        assign hit_o[i] = valid_i && !is_gang && (op != OP_IDLE) && (int'(pot_i) == i);
    end

endmodule

// File: rtl/wbank_chan.sv
module wbank_chan
    import wbank_pkg::*;
#(
    parameter int W     = 8,
    parameter int NREG  = 4,
    parameter int REG_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_i,
    input  logic             gang_i,
    input  logic [3:0]       op_i,
    input  logic [REG_W-1:0] reg_i,
    input  logic [W-1:0]     data_i,
    input  logic             up_i,
    output logic [W-1:0]     wiper_o,
    output logic [W-1:0]     rd_word_o
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    typedef struct packed {
        logic [W-1:0]            wcr;
        logic [NREG-1:0][W-1:0]  set;
    } chan_t;

    chan_t q, d;
    op_e   op;

    always_comb begin
        op = op_e'(op_i);
        d  = q;
        if (hit_i) begin
            case (op)
                OP_WR_WIPER: d.wcr        = data_i;
                OP_WR_SET:   d.set[reg_i] = data_i;
                OP_LOAD:     d.wcr        = q.set[reg_i];
                OP_STORE:    d.set[reg_i] = q.wcr;
                OP_STEP: begin
                    if (up_i && q.wcr != TOP)        d.wcr = q.wcr + 1'b1;
                    else if (!up_i && q.wcr != '0)   d.wcr = q.wcr - 1'b1;
                end
                default: ;
            endcase
        end
        if (gang_i) begin
            if (op == OP_GANG_LOAD)      d.wcr        = q.set[reg_i];
            else if (op == OP_GANG_STOR) d.set[reg_i] = q.wcr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign wiper_o   = q.wcr;
    assign rd_word_o = (op == OP_RD_WIPER) ? q.wcr : q.set[reg_i];

    p_step_up_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_i && op == OP_STEP && up_i && q.wcr != TOP) |=> (q.wcr == $past(q.wcr) + 1'b1));

    p_step_dn_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_i && op == OP_STEP && !up_i && q.wcr != '0) |=> (q.wcr == $past(q.wcr) - 1'b1));

    p_no_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_i && op == OP_STEP && ((up_i && q.wcr == TOP) || (!up_i && q.wcr == '0)))
        |=> $stable(q.wcr));

    p_gang_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (gang_i && op == OP_GANG_LOAD) |=> (q.wcr == $past(q.set[reg_i])));

    p_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_i && !gang_i) |=> $stable(q));

endmodule

// File: rtl/wiper_bank.sv
module wiper_bank
    import wbank_pkg::*;
#(
    parameter int NCH   = 2,
    parameter int W     = 8,
    parameter int NREG  = 4,
    parameter int POT_W = 2,
    parameter int REG_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [3:0]       cmd_op,
    input  logic [POT_W-1:0] cmd_pot,
    input  logic [REG_W-1:0] cmd_reg,
    input  logic [W-1:0]     cmd_data,
    input  logic             cmd_up,
    output logic [NCH*W-1:0] wiper_codes,
    output logic [W-1:0]     rd_data
);
    logic [NCH-1:0]        hit;
    logic                  gang;
    logic                  rd_en;
    logic [NCH-1:0][W-1:0] rd_word;
    logic [W-1:0]          rd_d, rd_q;

    wbank_decode #(.NCH(NCH), .POT_W(POT_W)) i_decode (
        .valid_i (cmd_valid),
        .op_i    (cmd_op),
        .pot_i   (cmd_pot),
        .hit_o   (hit),
        .gang_o  (gang),
        .rd_en_o (rd_en)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        wbank_chan #(.W(W), .NREG(NREG), .REG_W(REG_W)) i_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .hit_i     (hit[i]),
            .gang_i    (gang),
            .op_i      (cmd_op),
            .reg_i     (cmd_reg),
            .data_i    (cmd_data),
            .up_i      (cmd_up),
            .wiper_o   (wiper_codes[i*W +: W]),
            .rd_word_o (rd_word[i])
        );
    end

    always_comb begin
        rd_d = rd_q;
        if (rd_en) rd_d = rd_word[cmd_pot[$clog2(NCH > 1 ? NCH : 2)-1:0]];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_data = rd_q;

    p_one_channel_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));

    p_bad_pot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(cmd_pot) >= NCH && !gang) |=> ($stable(wiper_codes) && $stable(rd_data)));

    p_rd_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_valid) |=> ($stable(rd_data) && $stable(wiper_codes)));

endmodule

// File: tb/test_wiper_bank.sv
module test_wiper_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [3:0]  cmd_op = '0;
    logic [1:0]  cmd_pot = '0;
    logic [1:0]  cmd_reg = '0;
    logic [7:0]  cmd_data = '0;
    logic        cmd_up = 1'b0;
    logic [15:0] wiper_codes;
    logic [7:0]  rd_data;

    int checks = 0;
    int fails  = 0;

    logic [7:0] mw [2];
    logic [7:0] ms [2][4];
    logic [7:0] mrd;

    always #4 clk = ~clk;

    wiper_bank i_wiper_bank (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_pot(cmd_pot), .cmd_reg(cmd_reg), .cmd_data(cmd_data),
        .cmd_up(cmd_up), .wiper_codes(wiper_codes), .rd_data(rd_data)
    );

    task automatic compare(input string tag);
        logic [23:0] act, exp;
        act = {wiper_codes, rd_data};
        exp = {mw[1], mw[0], mrd};
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: wipers/rd actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_step(input logic v, input int op, input int pot,
                              input int rg, input logic [7:0] dat, input logic up);
        logic [7:0] w0 [2];
        logic [7:0] s0 [2][4];
        w0 = mw; s0 = ms;
        if (!v) return;
        if (op == 7 || op == 8) begin
            for (int c = 0; c < 2; c++) begin
                if (op == 7) mw[c] = s0[c][rg];
                else         ms[c][rg] = w0[c];
            end
            return;
        end
        if (pot > 1) return;
        case (op)
            1: mw[pot] = dat;
            2: ms[pot][rg] = dat;
            3: mrd = w0[pot];
            4: mrd = s0[pot][rg];
            5: mw[pot] = s0[pot][rg];
            6: ms[pot][rg] = w0[pot];
            9: begin
                if (up && w0[pot] != 8'hFF)      mw[pot] = w0[pot] + 8'd1;
                else if (!up && w0[pot] != 8'h00) mw[pot] = w0[pot] - 8'd1;
            end
            default: ;
        endcase
    endtask

    task automatic cmd(input logic v, input int op, input int pot, input int rg,
                       input logic [7:0] dat, input logic up, input string tag);
        @(negedge clk);
        cmd_valid = v; cmd_op = 4'(op); cmd_pot = 2'(pot); cmd_reg = 2'(rg);
        cmd_data = dat; cmd_up = up;
        @(posedge clk);
        model_step(v, op, pot, rg, dat, up);
        @(negedge clk);
        compare(tag);
        cmd_valid = 1'b0;
    endtask

    initial begin
        #200000;
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int c = 0; c < 2; c++) begin
            mw[c] = '0;
            for (int r = 0; r < 4; r++) ms[c][r] = '0;
        end
        mrd = '0;
        repeat (3) @(negedge clk);
        compare("R1 reset");
        rst_n = 1'b1;
        cmd(1, 4, 1, 3, 8'h00, 0, "R1 setting reads zero");

        cmd(1, 1, 0, 0, 8'h5A, 0, "R2 write wiper ch0");
        cmd(1, 1, 1, 0, 8'hC3, 0, "R2 write wiper ch1");
        cmd(1, 3, 0, 0, 8'h00, 0, "R4 read wiper ch0");
        cmd(1, 3, 1, 0, 8'h00, 0, "R4 read wiper ch1");

        for (int r = 0; r < 4; r++) begin
            cmd(1, 2, 0, r, 8'(8'h10 + r), 0, "R3 write setting ch0");
            cmd(1, 2, 1, r, 8'(8'hA0 + 3*r), 0, "R3 write setting ch1");
        end
        for (int r = 0; r < 4; r++) begin
            cmd(1, 4, 0, r, 8'h00, 0, "R3 read setting ch0");
            cmd(1, 4, 1, r, 8'h00, 0, "R3 read setting ch1");
        end

        cmd(1, 5, 0, 2, 8'h00, 0, "R5 load ch0 from set2");
        cmd(1, 5, 1, 3, 8'h00, 0, "R5 load ch1 from set3");
        cmd(1, 1, 0, 0, 8'h77, 0, "R2 rewrite ch0");
        cmd(1, 6, 0, 1, 8'h00, 0, "R6 store ch0 into set1");
        cmd(1, 4, 0, 1, 8'h00, 0, "R6 readback set1");

        cmd(1, 7, 3, 0, 8'h00, 0, "R7 gang load from set0");
        cmd(1, 1, 0, 0, 8'h3C, 0, "R2 wiper ch0");
        cmd(1, 1, 1, 0, 8'hE1, 0, "R2 wiper ch1");
        cmd(1, 8, 2, 2, 8'h00, 0, "R8 gang store into set2");
        cmd(1, 4, 0, 2, 8'h00, 0, "R8 readback ch0 set2");
        cmd(1, 4, 1, 2, 8'h00, 0, "R8 readback ch1 set2");

        cmd(1, 9, 0, 0, 8'h00, 1, "R9 step up ch0");
        cmd(1, 9, 0, 0, 8'h00, 1, "R9 step up ch0 again");
        cmd(1, 9, 1, 0, 8'h00, 0, "R9 step down ch1");
        cmd(1, 1, 0, 0, 8'hFF, 0, "R2 wiper top");
        cmd(1, 9, 0, 0, 8'h00, 1, "R10 step up at top");
        cmd(1, 9, 0, 0, 8'h00, 0, "R9 step down from top");
        cmd(1, 1, 1, 0, 8'h01, 0, "R2 wiper near bottom");
        cmd(1, 9, 1, 0, 8'h00, 0, "R9 step down to zero");
        cmd(1, 9, 1, 0, 8'h00, 0, "R10 step down at zero");

        cmd(1, 3, 0, 0, 8'h00, 0, "R4 set rd before bad pot");
        for (int p = 2; p < 4; p++) begin
            cmd(1, 1, p, 0, 8'h99, 0, "R11 write wiper bad pot");
            cmd(1, 2, p, 1, 8'h99, 0, "R11 write setting bad pot");
            cmd(1, 3, p, 0, 8'h00, 0, "R11 read bad pot");
            cmd(1, 9, p, 0, 8'h00, 1, "R11 step bad pot");
            cmd(1, 5, p, 0, 8'h00, 0, "R11 load bad pot");
        end
        cmd(1, 4, 0, 1, 8'h00, 0, "R11 setting intact ch0");
        cmd(1, 4, 1, 1, 8'h00, 0, "R11 setting intact ch1");

        cmd(0, 1, 0, 0, 8'h42, 0, "R12 strobe low write");
        cmd(0, 7, 0, 1, 8'h00, 0, "R12 strobe low gang");
        cmd(1, 0, 1, 0, 8'h42, 1, "R12 idle opcode");
        cmd(1, 4, 1, 0, 8'h00, 0, "R12 setting intact");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule